// File: doc/BRIEF.md
# Binary to BCD Decimal Adjuster

This block turns a 16-bit binary value into packed decimal digits. A start strobe captures the value together with two mode selects: width (low byte only, or the full word) and sign handling (unsigned, or two's complement). The block then runs a chain of divisions by decreasing powers of ten on one shared restoring divider. The divider yields one quotient bit per clock. Each quotient gives one decimal digit, and the remainder of the final division by ten gives the units digit.

In word mode the 16-bit result holds the thousands to units digits. The ten-thousands digit comes out on a 4-bit side field. In byte mode that side field carries status bits instead: zero, negative and a high-byte-present indication. The block raises busy while a conversion runs and emits a one-cycle done pulse when the result is written. A host, typically a math coprocessor sequencer, waits for done and then reads the digits for display or text output.

Top module: `bcd_adjust`

## Requirements
- R1: While reset is high at a clock edge, result, flags, busy and done all read zero after that edge.
- R2: Unsigned word mode: the value is taken as 0..65535. result[15:12], [11:8], [7:4] and [3:0] hold the thousands, hundreds, tens and units digits. flags holds the ten-thousands digit (for 0xD431: result 0x4321, flags 0x5).
- R3: Signed word mode: when bit 15 is set, the two's-complement magnitude is converted. Digits are placed as in R2, but flags bit 2 is replaced by the sign (for 0xD431: result 0x1215, flags 0x5).
- R4: Unsigned byte mode: only bits 7:0 are converted. result[15:12] is 0, and result[11:0] holds hundreds, tens and units. In flags, bit 0 is set when the whole result is zero, bit 1 is 0 and bit 2 is 0 (0x00FE gives 0x0254, flags 0x0).
- R5: Signed byte mode: when bit 7 is set, the 8-bit two's-complement magnitude is converted and flags bit 2 is set (0x00FE gives 0x0002, flags 0x4).
- R6: In byte mode, flags bit 3 is set when input bits 15:8 are nonzero. The upper byte has no effect on result or on the other flag bits.
- R7: Busy rises on the edge that accepts a start while idle. Busy stays high until the edge that writes the result. On that same edge done pulses high for exactly one cycle. Result and flags change only on that edge.
- R8: A start strobe that arrives while busy is ignored: the running conversion finishes with the values captured at its own start.
- R9: A word conversion writes its result 4*(DATA_W+1) = 68 cycles after the accepting edge. A byte conversion takes 2*(DATA_W+1) = 34 cycles.
- R10: Every nibble of result is a decimal digit (0 to 9) whenever done is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a conversion (taken only when idle) |
| value_i | input | 16 | Binary value to convert |
| word_i | input | 1 | 1 = full 16-bit word, 0 = low byte |
| signed_i | input | 1 | 1 = two's complement input, 0 = unsigned |
| result_o | output | 16 | Packed BCD digits |
| flags_o | output | 4 | Ten-thousands digit (word) or status bits (byte) |
| busy_o | output | 1 | High while a conversion runs |
| done_o | output | 1 | One-cycle pulse when result is written |

## Verification
The four combinations of width and sign are each run on the vector 0x00FE or 0xD431. These vectors separate negation from plain conversion and word digit placement from byte digit placement. The extremes 0x0000, 0xFFFF and 0x8000, and the byte value 0x80, show whether a digit is lost at the ten-thousands position or at the most negative input. A byte value with only the upper half set isolates the zero and high-byte-present bits from the digits. A second start pulsed mid-conversion with a different value and modes shows whether in-flight state is corrupted. Random values across all four modes then cover carries between digit stages, and each conversion's latency is measured against the expected cycle count.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  localparam int DATA_W  = 16;
  localparam int DIGIT_W = 4;
  localparam int NUM_DIV = 4;

  function automatic logic [DATA_W-1:0] pow10(input int n);
    logic [DATA_W-1:0] p;
    p = DATA_W'(1);
    for (int i = 0; i < n; i++) p = DATA_W'(p * 10);
    return p;
  endfunction
endpackage

// File: rtl/bcd_serial_div.sv
module bcd_serial_div #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic [W-1:0] quot_o,
  output logic [W-1:0] rem_o,
  output logic         fin_o
);
  localparam int CW = $clog2(W + 1);

  logic [2*W-1:0] acc;
  logic [W-1:0]   dvs;
  logic [CW-1:0]  cnt;
  logic           run;
  logic [W:0]     trial;

  assign trial  = {1'b0, acc[2*W-2:W-1]} - {1'b0, dvs};
  assign quot_o = acc[W-1:0];
  assign rem_o  = acc[2*W-1:W];

  always_ff @(posedge clk) begin
    if (rst) begin
      acc   <= '0;
      dvs   <= '0;
      cnt   <= '0;
      run   <= 1'b0;
      fin_o <= 1'b0;
    end else begin
      fin_o <= 1'b0;
      if (load_i) begin
        acc <= {{W{1'b0}}, dividend_i};
        dvs <= divisor_i;
        cnt <= '0;
        run <= 1'b1;
      end else if (run) begin
        if (trial[W]) acc <= {acc[2*W-2:0], 1'b0};
        else          acc <= {trial[W-1:0], acc[W-2:0], 1'b1};
        cnt <= cnt + 1'b1;
        if (cnt == CW'(W - 1)) begin
          run   <= 1'b0;
          fin_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/bcd_magnitude.sv
module bcd_magnitude #(
  parameter int W = 16
) (
  input  logic [W-1:0] value_i,
  input  logic         word_i,
  input  logic         signed_i,
  output logic [W-1:0] mag_o,
  output logic         neg_o,
  output logic         high_nz_o
);
  localparam int BW = W / 2;

  logic [BW-1:0] low;

  always_comb begin
    low       = value_i[BW-1:0];
    high_nz_o = |value_i[W-1:BW];
    if (word_i) begin
      neg_o = signed_i & value_i[W-1];
      mag_o = neg_o ? (~value_i + 1'b1) : value_i;
    end else begin
      neg_o = signed_i & value_i[BW-1];
      mag_o = {{(W-BW){1'b0}}, (neg_o ? BW'(~low + 1'b1) : low)};
    end
  end
endmodule

// File: rtl/bcd_sequencer.sv
module bcd_sequencer
  import bcd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              word_i,
  input  logic              signed_i,
  input  logic [DATA_W-1:0] mag_i,
  input  logic              neg_i,
  input  logic              high_nz_i,
  input  logic [DATA_W-1:0] quot_i,
  input  logic [DATA_W-1:0] rem_i,
  input  logic              fin_i,
  output logic              div_load_o,
  output logic [DATA_W-1:0] div_dividend_o,
  output logic [DATA_W-1:0] div_divisor_o,
  output logic [DATA_W-1:0] result_o,
  output logic [3:0]        flags_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int SW       = $clog2(NUM_DIV);
  localparam int LAST     = NUM_DIV - 1;
  localparam int BYTE_FST = NUM_DIV - 2;

  logic [SW-1:0]      stage;
  logic [SW-1:0]      next_stage;
  logic               word_q, sgn_q, neg_q, hnz_q;
  logic [DIGIT_W-1:0] d_tth, d_th, d_hu;
  logic               accept, last, step;
  logic [DIGIT_W-1:0] q_dig, r_dig;

  assign accept = start_i & ~busy_o;
  assign last   = (stage == SW'(LAST));
  assign step   = busy_o & fin_i;
  assign q_dig  = quot_i[DIGIT_W-1:0];
  assign r_dig  = rem_i[DIGIT_W-1:0];

  always_comb begin
    if (accept) next_stage = word_i ? '0 : SW'(BYTE_FST);
    else        next_stage = stage + 1'b1;
    div_load_o     = accept | (step & ~last);
    div_dividend_o = accept ? mag_i : rem_i;
    div_divisor_o  = pow10(NUM_DIV - int'(next_stage));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stage    <= '0;
      word_q   <= 1'b0;
      sgn_q    <= 1'b0;
      neg_q    <= 1'b0;
      hnz_q    <= 1'b0;
      d_tth    <= '0;
      d_th     <= '0;
      d_hu     <= '0;
      result_o <= '0;
      flags_o  <= '0;
      busy_o   <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (accept) begin
        busy_o <= 1'b1;
        stage  <= next_stage;
        word_q <= word_i;
        sgn_q  <= signed_i;
        neg_q  <= neg_i;
        hnz_q  <= high_nz_i;
        d_tth  <= '0;
        d_th   <= '0;
        d_hu   <= '0;
      end else if (step) begin
        case (stage)
          SW'(0): d_tth <= q_dig;
          SW'(1): d_th  <= q_dig;
          SW'(2): d_hu  <= q_dig;
          default: ;
        endcase
        if (last) begin
          busy_o   <= 1'b0;
          done_o   <= 1'b1;
          result_o <= {d_th, d_hu, q_dig, r_dig};
          if (word_q)
            flags_o <= {d_tth[3], (sgn_q ? neg_q : d_tth[2]), d_tth[1:0]};
          else
            flags_o <= {hnz_q, neg_q, 1'b0,
                        (d_hu == '0) && (q_dig == '0) && (r_dig == '0)};
        end else begin
          stage <= next_stage;
        end
      end
    end
  end
endmodule

// File: rtl/bcd_adjust.sv
module bcd_adjust
  import bcd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [DATA_W-1:0] value_i,
  input  logic              word_i,
  input  logic              signed_i,
  output logic [DATA_W-1:0] result_o,
  output logic [3:0]        flags_o,
  output logic              busy_o,
  output logic              done_o
);
  logic [DATA_W-1:0] mag, quot, rem, dvd, dvs;
  logic              neg, high_nz, fin, load;

  bcd_magnitude #(.W(DATA_W)) u_mag (
    .value_i   (value_i),
    .word_i    (word_i),
    .signed_i  (signed_i),
    .mag_o     (mag),
    .neg_o     (neg),
    .high_nz_o (high_nz)
  );

  bcd_serial_div #(.W(DATA_W)) u_div (
    .clk        (clk),
    .rst        (rst),
    .load_i     (load),
    .dividend_i (dvd),
    .divisor_i  (dvs),
    .quot_o     (quot),
    .rem_o      (rem),
    .fin_o      (fin)
  );

  bcd_sequencer u_seq (
    .clk            (clk),
    .rst            (rst),
    .start_i        (start_i),
    .word_i         (word_i),
    .signed_i       (signed_i),
    .mag_i          (mag),
    .neg_i          (neg),
    .high_nz_i      (high_nz),
    .quot_i         (quot),
    .rem_i          (rem),
    .fin_i          (fin),
    .div_load_o     (load),
    .div_dividend_o (dvd),
    .div_divisor_o  (dvs),
    .result_o       (result_o),
    .flags_o        (flags_o),
    .busy_o         (busy_o),
    .done_o         (done_o)
  );
endmodule

// File: rtl/bcd_adjust_chk.sv
module bcd_adjust_chk
  import bcd_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic [DATA_W-1:0] result_o,
  input logic [3:0]        flags_o,
  input logic              busy_o,
  input logic              done_o
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (result_o == '0 && flags_o == '0 && !busy_o && !done_o));

  assert_done_on_busy_fall_R7: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && $past(busy_o)));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_busy_after_start_R7: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> busy_o);

  assert_busy_rise_cause_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(start_i));

  assert_result_held_R7: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> ($stable(result_o) && $stable(flags_o)));

  assert_decimal_digits_R10: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (result_o[15:12] <= 4'd9 && result_o[11:8] <= 4'd9 &&
                result_o[7:4] <= 4'd9 && result_o[3:0] <= 4'd9));
endmodule

bind bcd_adjust bcd_adjust_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .start_i  (start_i),
  .result_o (result_o),
  .flags_o  (flags_o),
  .busy_o   (busy_o),
  .done_o   (done_o)
);

// File: tb/bcd_adjust_tb.sv
module bcd_adjust_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [15:0] value_i = '0;
  logic        word_i = 1'b0;
  logic        signed_i = 1'b0;
  logic [15:0] result_o;
  logic [3:0]  flags_o;
  logic        busy_o, done_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  bcd_adjust u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .value_i(value_i),
    .word_i(word_i), .signed_i(signed_i), .result_o(result_o),
    .flags_o(flags_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic void model(input logic [15:0] v, input logic w, input logic s,
                                output logic [15:0] r, output logic [3:0] f);
    int mag;
    logic neg;
    logic [3:0] d4, d3, d2, d1, d0;
    if (w) begin
      neg = s & v[15];
      mag = neg ? (65536 - int'(v)) : int'(v);
    end else begin
      neg = s & v[7];
      mag = neg ? ((256 - int'(v[7:0])) % 256) : int'(v[7:0]);
    end
    d4 = 4'((mag / 10000) % 10);
    d3 = 4'((mag / 1000) % 10);
    d2 = 4'((mag / 100) % 10);
    d1 = 4'((mag / 10) % 10);
    d0 = 4'(mag % 10);
    r = {d3, d2, d1, d0};
    if (w) begin
      f = d4;
      if (s) f[2] = neg;
    end else begin
      f = {|v[15:8], neg, 1'b0, (mag == 0)};
    end
  endfunction

  // poke: issue a second, different start while the first is running (R8)
  task automatic convert(input logic [15:0] v, input logic w, input logic s,
                         input bit poke, input string tag);
    logic [15:0] er;
    logic [3:0]  ef;
    int n;
    model(v, w, s, er, ef);
    @(negedge clk);
    value_i = v; word_i = w; signed_i = s; start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    n = 1;
    check({"R7 busy after start ", tag}, 32'(busy_o), 32'd1);
    if (poke) begin
      repeat (5) @(negedge clk);
      value_i = ~v; word_i = ~w; signed_i = ~s; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      n += 6;
      check({"R8 busy held on late start ", tag}, 32'(busy_o), 32'd1);
    end
    while (!done_o && n < 400) begin
      @(posedge clk); n++;
      @(negedge clk);
    end
    check({"R7 done seen ", tag}, 32'(done_o), 32'd1);
    check({"R7 busy low at done ", tag}, 32'(busy_o), 32'd0);
    check({"R9 latency ", tag}, 32'(n - 1), w ? 32'd68 : 32'd34);
    check({"R2-5 result ", tag}, 32'(result_o), 32'(er));
    check({"R2-5 flags ", tag}, 32'(flags_o), 32'(ef));
    check({"R10 digits ", tag}, 32'((result_o[15:12] > 9) || (result_o[11:8] > 9) ||
                                    (result_o[7:4] > 9) || (result_o[3:0] > 9)), 32'd0);
    @(negedge clk);
    check({"R7 done one cycle ", tag}, 32'(done_o), 32'd0);
    check({"R7 result held ", tag}, 32'(result_o), 32'(er));
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset result", 32'(result_o), 32'd0);
    check("R1 reset flags", 32'(flags_o), 32'd0);
    check("R1 reset busy", 32'(busy_o), 32'd0);
    check("R1 reset done", 32'(done_o), 32'd0);
    rst = 1'b0;

    convert(16'h00FE, 1'b0, 1'b0, 0, "R4 ubyte FE");
    convert(16'h00FE, 1'b0, 1'b1, 0, "R5 sbyte FE");
    convert(16'hD431, 1'b1, 1'b0, 0, "R2 uword D431");
    convert(16'hD431, 1'b1, 1'b1, 0, "R3 sword D431");
    convert(16'h0000, 1'b1, 1'b0, 0, "R2 uword zero");
    convert(16'hFFFF, 1'b1, 1'b0, 0, "R2 uword max");
    convert(16'h8000, 1'b1, 1'b1, 0, "R3 sword min");
    convert(16'h0080, 1'b0, 1'b1, 0, "R5 sbyte min");
    convert(16'hAB00, 1'b0, 1'b0, 0, "R6 byte upper only");
    convert(16'h5A7F, 1'b0, 1'b1, 0, "R6 byte upper ignored");
    convert(16'h1234, 1'b1, 1'b0, 1, "R8 late start word");
    convert(16'h00C3, 1'b0, 1'b1, 1, "R8 late start byte");

    for (int i = 0; i < 60; i++) begin
      logic [15:0] v;
      logic [1:0] m;
      v = 16'($urandom);
      m = 2'($urandom);
      convert(v, m[1], m[0], 0, "random R2 R3 R4 R5");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule